// File: doc/BRIEF.md
# Codec Interrupt Flag and Mask Controller

This block gathers seven single-cycle event pulses from an audio codec's analog and gain logic into a sticky flag register. It combines those flags with a per-bit mask and drives one interrupt request line toward the host. Software reaches three byte-wide registers through a small register port: a control register, a mask register and the flag register. The control register holds a 2-bit field that picks the electrical form of the request: high or low level, or a high or low single-cycle pulse.

A driver typically unmasks only the sources it waits for, such as a headphone ramp or a digital gain step. It waits for the request, reads the flags live, and writes ones back to acknowledge the bits it handled. The block does not generate the events.

Top module: `irqc_top`

## Requirements
- R1: After reset the flag register reads 0x00, the mask register reads 0x7F, the control register reads 0x00 and `irq` is low.
- R2: An `ev_pulse` bit high for one cycle sets the flag bit at the same position. Bit 6 is short-circuit release, bit 5 is jack change, bit 4 is short-circuit, bit 3 is ramp-up done, bit 2 is ramp-down done, bit 1 is gain-up done and bit 0 is gain-down done. Flags are never set any other way.
- R3: A write to the flag register (address 2) clears every flag whose data bit is 1 and leaves the rest unchanged. Writing 0x7F clears all flags, and data bit 7 has no effect.
- R4: When an event and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R5: The mask register (address 1) stores data bits 6:0 and reads 0 in bit 7. A mask bit of 1 keeps the matching flag from affecting `irq`.
- R6: With form 0, `irq` is high exactly when some unmasked flag is set, one clock after the flag or mask register changes.
- R7: With form 1, `irq` is the inverse of the form 0 level, with the same one-clock delay.
- R8: With form 2, `irq` is high for one cycle, one clock after the set of unmasked set flags gains a bit. The bit can be gained through a new event or through unmasking a flag that is already set. A repeat event on a flag that is already set gives no pulse.
- R9: With form 3, `irq` idles high and drops low for one cycle under the conditions of R8.
- R10: The control register (address 0) holds the form in bits 7:6 and reads 0 in bits 5:0. Address 3 reads 0x00.
- R11: Reading the flag register returns its live value and does not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the addressed register |
| reg_addr | input | 2 | Register select: 0 control, 1 mask, 2 flags |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Live read data of the addressed register |
| ev_pulse | input | 7 | One-cycle event pulses, one per flag bit |
| irq | output | 1 | Interrupt request in the selected form |

## Verification
An event pulse and an acknowledging write can land on the same flag in the same cycle. The bench provokes this by driving `ev_pulse` and a flag write with overlapping bits on one clock edge, and expects the flag to read back as set. It then repeats the collision with disjoint bits, where the written bit must clear and the event bit must set. A second overlap is a mask write that exposes a flag set earlier: in pulse form this must fire exactly one pulse even though no event occurred in that cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    parameter int NUM_SRC = 7;
    parameter int DATA_W  = 8;
    parameter int ADDR_W  = 2;

    localparam int FORM_LSB = DATA_W - 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_FLAG = ADDR_W'(2);

    typedef enum logic [1:0] {
        FORM_LVL_HI = 2'd0,
        FORM_LVL_LO = 2'd1,
        FORM_PLS_HI = 2'd2,
        FORM_PLS_LO = 2'd3
    } form_e;

    typedef struct packed {
        form_e              form;
        logic [NUM_SRC-1:0] mask;
    } cfg_s;

    typedef struct packed {
        logic [NUM_SRC-1:0] flag;
    } flag_s;

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
        logic               irq;
    } drv_s;

endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic               wr_mask,
    input  logic [1:0]         form_wdata,
    input  logic [NUM_SRC-1:0] mask_wdata,
    output form_e              form,
    output logic [NUM_SRC-1:0] mask
);

    cfg_s cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl) begin
            cfg_d.form = form_e'(form_wdata);
        end
        if (wr_mask) begin
            cfg_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.form <= FORM_LVL_HI;
            cfg_q.mask <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign form = cfg_q.form;
    assign mask = cfg_q.mask;

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask == $past(mask_wdata))) // R5
        else $error("mask write not stored");

    AST_FORM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(form)) // R10
        else $error("form changed without a write");

endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_flag,
    input  logic [NUM_SRC-1:0] clr_bits,
    input  logic [NUM_SRC-1:0] ev,
    output logic [NUM_SRC-1:0] flags
);

    flag_s fl_d, fl_q;
    logic [NUM_SRC-1:0] ack;

    always_comb begin
        ack       = wr_flag ? clr_bits : '0;
        fl_d.flag = (fl_q.flag & ~ack) | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q.flag;

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((flags & $past(ev)) == $past(ev))) // R4
        else $error("event lost");

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && ev == '0) |=> ((flags & $past(clr_bits)) == '0)) // R3
        else $error("flag not cleared");

    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == '0) |=> ((flags & ~$past(flags)) == '0)) // R2
        else $error("flag set without event");

endmodule

// File: rtl/irqc_drive.sv
module irqc_drive
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  form_e              form,
    input  logic [NUM_SRC-1:0] pend,
    output logic               irq
);

    drv_s dr_d, dr_q;
    logic any_pend;
    logic fresh;

    always_comb begin
        any_pend  = |pend;
        fresh     = |(pend & ~dr_q.prev);
        dr_d.prev = pend;
        unique case (form)
            FORM_LVL_HI: dr_d.irq = any_pend;
            FORM_LVL_LO: dr_d.irq = ~any_pend;
            FORM_PLS_HI: dr_d.irq = fresh;
            FORM_PLS_LO: dr_d.irq = ~fresh;
            default:     dr_d.irq = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else begin
            dr_q <= dr_d;
        end
    end

    assign irq = dr_q.irq;

    AST_LEVEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(form) == FORM_LVL_HI && $past(pend) == '0) |-> !irq) // R6
        else $error("high level request without pending source");

    AST_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(form) == FORM_LVL_LO && $past(pend) == '0) |-> irq) // R7
        else $error("low level request without pending source");

    AST_PULSE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(form) == FORM_PLS_HI && $past(pend) == '0) |-> !irq) // R8
        else $error("pulse with nothing pending");

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NUM_SRC-1:0] ev_pulse,
    output logic              irq
);

    form_e              form;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] pend;
    logic               wr_ctrl, wr_mask, wr_flag;

    always_comb begin
        wr_ctrl = reg_wr_en && (reg_addr == ADDR_CTRL);
        wr_mask = reg_wr_en && (reg_addr == ADDR_MASK);
        wr_flag = reg_wr_en && (reg_addr == ADDR_FLAG);
    end

    irqc_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_mask    (wr_mask),
        .form_wdata (reg_wdata[DATA_W-1:FORM_LSB]),
        .mask_wdata (reg_wdata[NUM_SRC-1:0]),
        .form       (form),
        .mask       (mask)
    );

    irqc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_flag  (wr_flag),
        .clr_bits (reg_wdata[NUM_SRC-1:0]),
        .ev       (ev_pulse),
        .flags    (flags)
    );

    assign pend = flags & ~mask;

    irqc_drive u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .form  (form),
        .pend  (pend),
        .irq   (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: reg_rdata[DATA_W-1:FORM_LSB] = form;
            ADDR_MASK: reg_rdata[NUM_SRC-1:0]       = mask;
            ADDR_FLAG: reg_rdata[NUM_SRC-1:0]       = flags;
            default:   reg_rdata                    = '0;
        endcase
    end

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask) == '1 && $past(form) == FORM_LVL_HI) |-> !irq) // R5
        else $error("request while all sources masked");

endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
    import irqc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [6:0]  ev_pulse = 7'd0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        bit        is_irq;
        logic [7:0] exp;
        string     tag;
    } item_t;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev_pulse), .irq(irq)
    );

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {7'd0, irq} : reg_rdata;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic ev(input logic [6:0] bits);
        ev_pulse = bits;
        tick();
        ev_pulse = 7'd0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        tick();
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        irq_chk(1'b0, "R1 irq");
        rd_chk(2'd0, 8'h00, "R1 ctrl");
        rd_chk(2'd1, 8'h7F, "R1 mask");
        rd_chk(2'd2, 8'h00, "R1 flags");

        // R2 events set flags; all masked so no request (R5)
        ev(7'h05);
        rd_chk(2'd2, 8'h05, "R2 flags 05");
        irq_chk(1'b0, "R5 masked");
        tick();

        // R5 mask write, bit 7 ignored; R6 level after unmask
        wr(2'd1, 8'hFB);
        rd_chk(2'd1, 8'h7B, "R5 mask readback");
        irq_chk(1'b1, "R6 level high");

        // R3 write one to clear, zero keeps
        wr(2'd2, 8'h01);
        rd_chk(2'd2, 8'h04, "R3 clear bit0");
        wr(2'd2, 8'h80);
        rd_chk(2'd2, 8'h04, "R3 zero and bit7 keep");
        irq_chk(1'b1, "R6 still high");
        // R11 repeated read leaves flags
        rd_chk(2'd2, 8'h04, "R11 reread");
        wr(2'd2, 8'h04);
        tick();
        irq_chk(1'b0, "R6 level low after clear");
        rd_chk(2'd2, 8'h00, "R3 all clear");

        // R4 event and clear collide
        ev_pulse = 7'h08; reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h08;
        tick();
        ev_pulse = 7'h00; reg_wr_en = 1'b0;
        rd_chk(2'd2, 8'h08, "R4 event wins");
        ev_pulse = 7'h10; reg_wr_en = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h08;
        tick();
        ev_pulse = 7'h00; reg_wr_en = 1'b0;
        rd_chk(2'd2, 8'h10, "R4 disjoint collide");
        wr(2'd2, 8'h7F);
        rd_chk(2'd2, 8'h00, "R3 clear all 7F");

        // R7 active low level
        wr(2'd0, 8'h40);
        tick();
        rd_chk(2'd0, 8'h40, "R10 ctrl form1");
        irq_chk(1'b1, "R7 idle high");
        ev(7'h04);
        tick();
        irq_chk(1'b0, "R7 asserted low");
        wr(2'd2, 8'h7F);
        tick();
        irq_chk(1'b1, "R7 released");

        // R8 high pulse
        wr(2'd0, 8'hBF);
        tick();
        rd_chk(2'd0, 8'h80, "R10 ctrl low bits zero");
        irq_chk(1'b0, "R8 idle");
        ev(7'h04);
        irq_chk(1'b0, "R8 not yet");
        tick();
        irq_chk(1'b1, "R8 pulse");
        tick();
        irq_chk(1'b0, "R8 one cycle");
        ev(7'h04);
        tick();
        irq_chk(1'b0, "R8 repeat no pulse");
        wr(2'd1, 8'h5B);
        tick();
        ev(7'h20);
        tick();
        irq_chk(1'b1, "R8 jack pulse");
        tick();
        ev(7'h02);
        tick();
        irq_chk(1'b0, "R8 masked event");
        wr(2'd1, 8'h59);
        tick();
        irq_chk(1'b1, "R8 pulse on unmask");
        tick();
        irq_chk(1'b0, "R8 unmask one cycle");
        wr(2'd2, 8'h7F);
        tick();

        // R9 low pulse
        wr(2'd0, 8'hC0);
        tick();
        irq_chk(1'b1, "R9 idle high");
        ev(7'h04);
        tick();
        irq_chk(1'b0, "R9 low pulse");
        tick();
        irq_chk(1'b1, "R9 one cycle");

        // R10 unused address
        rd_chk(2'd3, 8'h00, "R10 addr3");

        tick();
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule